// File: doc/BRIEF.md
# SHA-256 Block Compression Engine with Handshake Flags

This block computes SHA-256 chaining values one 512-bit block at a time. Software (or a DMA engine) feeds it 32-bit message words through a write strobe; the block has no input FIFO, so each accepted word is consumed straight away by the round logic. The first 16 rounds run in step with the 16 word writes. The remaining 48 rounds and the final chaining addition run on their own during a fixed busy window that follows the last word of the block.

A start pulse reloads the eight digest registers with the standard SHA-256 initial hash values and clears the word, round and busy counters. Three flags guide the host. `ready_o` says a word may be written. `valid_o` says the 256-bit digest output is a finished result. The sticky `err_o` records any attempt to write while the block was not ready. Padding and length encoding are done by the host, which supplies whole padded blocks. Without a start pulse between blocks, each block chains onto the previous result, which is how multi-block messages are hashed.

Top module: `hash_engine_ctl`

## Requirements
- R1: After reset, and one cycle after a start pulse, the digest output equals the SHA-256 initial values 6a09e667 bb67ae85 3c6ef372 a54ff53a 510e527f 9b05688c 1f83d9ab 5be0cd19, and any partly written block is discarded.
- R2: One cycle after a start pulse, both `ready_o` and `valid_o` are 1. A word write in the same cycle as start is dropped and raises no error.
- R3: A block is 16 accepted words. The word accepted first is message word 0. Once the block completes, the digest of the padded single block "abc" (61626380, fourteen zero words, 00000018) equals ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad.
- R4: `ready_o` goes low in the cycle after the 16th word is accepted and stays low for exactly 57 cycles.
- R5: `valid_o` goes low in the cycle after the first word of a block is accepted. It returns high in the same cycle that `ready_o` returns high at the end of that block.
- R6: A write strobe while `ready_o` is 0 sets `err_o` in the next cycle. `err_o` then stays 1 until an `err_clr_i` pulse clears it. If both happen in one cycle, the set wins.
- R7: A word written while `ready_o` is 0 is dropped: it changes neither the message schedule, the counters nor the digest.
- R8: At the end of a block, each of the eight digest words is updated by adding the matching working variable modulo 2^32. The next block, written without a start pulse, chains from that value; the two-block 56-byte test message gives 248d6a61 d20638b8 e5c02693 0c3e6039 a33ce459 64ff2167 f6ecedd4 19db06c1.
- R9: `sum_o` carries digest word 0 in bits 255:224 and digest word 7 in bits 31:0. It changes only while `ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse: load initial values, clear counters |
| wr_i | input | 1 | Word write strobe |
| wdata_i | input | 32 | Message word to write |
| err_clr_i | input | 1 | Clear pulse for the error flag |
| ready_o | output | 1 | Engine can accept a word |
| valid_o | output | 1 | Digest output is a finished result |
| err_o | output | 1 | Sticky flag: a write arrived while not ready |
| sum_o | output | 256 | Digest words 0..7, word 0 in the top bits |

## Verification
A wrong word counter shows up as a busy window that starts on the wrong write, or as a busy window that is not exactly 57 cycles long. Either is visible at `ready_o` within one block. A corrupted schedule word, round constant or working variable cannot be seen until the block completes, about 60 cycles after the last write. The full 256-bit comparison against the known vectors then exposes it. A wrong chaining addition, or a dropped write that leaked into the state, appears only in the digest of the next completed block. For that reason the two-block vector is run with an illegal write injected during the first block's busy window.

// File: rtl/sha_eng_pkg.sv
package sha_eng_pkg;

   typedef logic [31:0]      word_t;
   typedef logic [7:0][31:0] vars_t;   // index 0 = a / digest word 0

   localparam vars_t IV = {
      32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
      32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};

   localparam word_t K_TAB [64] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
      32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
      32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
      32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
      32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
      32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
      32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
      32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
      32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

   function automatic word_t rotr(input word_t x, input int n);
      logic [63:0] dbl;
      dbl = {x, x} >> n;
      return dbl[31:0];
   endfunction

   function automatic word_t big_sig0(input word_t x);
      return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
   endfunction

   function automatic word_t big_sig1(input word_t x);
      return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
   endfunction

   function automatic word_t sml_sig0(input word_t x);
      return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
   endfunction

   function automatic word_t sml_sig1(input word_t x);
      return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
   endfunction

endpackage

// File: rtl/sha_round.sv
module sha_round
   import sha_eng_pkg::*;
(
   input  vars_t st_i,
   input  word_t k_i,
   input  word_t w_i,
   output vars_t st_o
);
   word_t t1, t2, ch, maj;

   always_comb begin
      ch   = (st_i[4] & st_i[5]) ^ (~st_i[4] & st_i[6]);
      maj  = (st_i[0] & st_i[1]) ^ (st_i[0] & st_i[2]) ^ (st_i[1] & st_i[2]);
      t1   = st_i[7] + big_sig1(st_i[4]) + ch + k_i + w_i;
      t2   = big_sig0(st_i[0]) + maj;
      st_o = {st_i[6], st_i[5], st_i[4], st_i[3] + t1,
              st_i[2], st_i[1], st_i[0], t1 + t2};
   end
endmodule

// File: rtl/sha_sched.sv
module sha_sched
   import sha_eng_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  shift_i,
   input  logic  use_ext_i,
   input  word_t ext_i,
   output word_t w_o
);
   word_t win [DEPTH];
   word_t grown;

   always_comb begin
      grown = sml_sig1(win[DEPTH-2]) + win[DEPTH-7] + sml_sig0(win[1]) + win[0];
      w_o   = use_ext_i ? ext_i : grown;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_win
      if (i == DEPTH - 1) begin : g_head
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)       win[i] <= '0;
            else if (shift_i) win[i] <= w_o;
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)       win[i] <= '0;
            else if (shift_i) win[i] <= win[i+1];
      end
   end
endmodule

// File: rtl/sha_ctrl.sv
module sha_ctrl #(
   parameter int BLOCK_WORDS = 16,
   parameter int ROUNDS      = 64,
   parameter int BUSY_CYCLES = 57,
   localparam int CNT_W  = $clog2(BLOCK_WORDS),
   localparam int TMR_W  = $clog2(BUSY_CYCLES + 1),
   localparam int RND_W  = $clog2(ROUNDS + 2),
   localparam int STEP_W = $clog2(ROUNDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              wr_i,
   input  logic              err_clr_i,
   output logic              accept_o,
   output logic              first_o,
   output logic              round_en_o,
   output logic              fin_o,
   output logic [STEP_W-1:0] step_o,
   output logic              ready_o,
   output logic              valid_o,
   output logic              err_o
);
   logic [CNT_W-1:0] wcnt;
   logic [TMR_W-1:0] timer;
   logic [RND_W-1:0] rnd;
   logic             busy, bad_wr;

   assign busy       = (timer != '0);
   assign ready_o    = !busy;
   assign accept_o   = wr_i && !busy && !start_i;
   assign bad_wr     = wr_i && busy && !start_i;
   assign first_o    = accept_o && (wcnt == '0);
   assign round_en_o = accept_o || (busy && rnd < RND_W'(ROUNDS));
   assign fin_o      = busy && (rnd == RND_W'(ROUNDS));
   assign step_o     = accept_o ? STEP_W'(wcnt) : rnd[STEP_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt <= '0; timer <= '0; rnd <= '0; valid_o <= 1'b1;
      end else if (start_i) begin
         wcnt <= '0; timer <= '0; rnd <= '0; valid_o <= 1'b1;
      end else begin
         if (accept_o) begin
            wcnt <= wcnt + 1'b1;   // wraps to 0 after the last word
            if (wcnt == CNT_W'(BLOCK_WORDS - 1)) begin
               timer <= TMR_W'(BUSY_CYCLES);
               rnd   <= RND_W'(BLOCK_WORDS);
            end
         end else if (busy) begin
            timer <= timer - 1'b1;
            if (rnd <= RND_W'(ROUNDS)) rnd <= rnd + 1'b1;
         end
         if (first_o)                     valid_o <= 1'b0;
         else if (timer == TMR_W'(1))     valid_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         err_o <= 1'b0;
      else if (bad_wr)    err_o <= 1'b1;
      else if (err_clr_i) err_o <= 1'b0;
endmodule

// File: rtl/hash_engine_ctl.sv
module hash_engine_ctl
   import sha_eng_pkg::*;
#(
   parameter int BLOCK_WORDS = 16,
   parameter int ROUNDS      = 64,
   parameter int BUSY_CYCLES = 57,
   localparam int STEP_W     = $clog2(ROUNDS)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         wr_i,
   input  logic [31:0]  wdata_i,
   input  logic         err_clr_i,
   output logic         ready_o,
   output logic         valid_o,
   output logic         err_o,
   output logic [255:0] sum_o
);
   if (BLOCK_WORDS != 16 || ROUNDS != 64) begin : g_bad_shape
      $error("hash_engine_ctl: block must be 16 words and 64 rounds");
   end
   if (BUSY_CYCLES < ROUNDS - BLOCK_WORDS + 1) begin : g_bad_busy
      $error("hash_engine_ctl: busy window too short for remaining rounds");
   end

   logic              accept, first, round_en, fin;
   logic [STEP_W-1:0] step;
   word_t             w_cur;
   vars_t             sums, work, rnd_in, rnd_out, sums_add;

   sha_ctrl #(.BLOCK_WORDS(BLOCK_WORDS), .ROUNDS(ROUNDS),
              .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
      .err_clr_i(err_clr_i), .accept_o(accept), .first_o(first),
      .round_en_o(round_en), .fin_o(fin), .step_o(step),
      .ready_o(ready_o), .valid_o(valid_o), .err_o(err_o));

   sha_sched #(.DEPTH(BLOCK_WORDS)) u_sched (
      .clk(clk), .rst_n(rst_n), .shift_i(round_en), .use_ext_i(accept),
      .ext_i(wdata_i), .w_o(w_cur));

   assign rnd_in = first ? sums : work;

   sha_round u_round (
      .st_i(rnd_in), .k_i(K_TAB[step]), .w_i(w_cur), .st_o(rnd_out));

   for (genvar i = 0; i < 8; i++) begin : g_word
      assign sums_add[i]               = sums[i] + work[i];
      assign sum_o[255-32*i -: 32]     = sums[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sums <= IV;
         work <= '0;
      end else if (start_i) begin
         sums <= IV;
      end else begin
         if (round_en) work <= rnd_out;
         if (fin)      sums <= sums_add;
      end
   end
endmodule

// File: rtl/hash_engine_ctl_chk.sv
module hash_engine_ctl_chk #(
   parameter int BUSY_CYCLES = 57
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         wr_i,
   input logic         err_clr_i,
   input logic         ready_o,
   input logic         valid_o,
   input logic         err_o,
   input logic [255:0] sum_o
);
   localparam int LC_W = $clog2(BUSY_CYCLES + 2) + 1;
   logic [LC_W-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                       low_cnt <= '0;
      else if (ready_o)                 low_cnt <= '0;
      else if (low_cnt != '1)           low_cnt <= low_cnt + 1'b1;

   AST_START_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> ready_o && valid_o);                                   // R2
   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) && !$past(start_i) |-> low_cnt == LC_W'(BUSY_CYCLES)); // R4
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o && valid_o && wr_i && !start_i |=> !valid_o);              // R5
   AST_VALID_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> valid_o);                                       // R5
   AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && !ready_o && !start_i |=> err_o);                           // R6
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      err_o && !err_clr_i |=> err_o);                                    // R6
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr_i && !(wr_i && !ready_o && !start_i) |=> !err_o);          // R6
   AST_SUM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o && !start_i |=> $stable(sum_o));                           // R9
endmodule

bind hash_engine_ctl hash_engine_ctl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
   .err_clr_i(err_clr_i), .ready_o(ready_o), .valid_o(valid_o),
   .err_o(err_o), .sum_o(sum_o));

// File: tb/hash_engine_ctl_test.sv
`timescale 1ns/1ps
module hash_engine_ctl_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0, wr_i = 1'b0, err_clr_i = 1'b0;
   logic [31:0]  wdata_i = '0;
   logic         ready_o, valid_o, err_o;
   logic [255:0] sum_o;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [255:0] exp_q [$];
   logic [31:0]  blk [16];

   localparam logic [255:0] IV_V  = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
   localparam logic [255:0] ABC_V = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
   localparam logic [255:0] EMP_V = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
   localparam logic [255:0] TWO_V = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;

   always #2 clk = ~clk;

   hash_engine_ctl uut (.*);

   task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // scoreboard monitor: compare when a block's busy window ends
   logic prev_rdy = 1'b1;
   always @(negedge clk) begin
      if (rst_n && ready_o && !prev_rdy && exp_q.size() > 0) begin
         logic [255:0] e;
         e = exp_q.pop_front();
         check(sum_o == e, "R3/R8 digest", sum_o, e);
         check(valid_o == 1'b1, "R5 valid with ready", {255'd0, valid_o}, 256'd1);
      end
      prev_rdy = ready_o;
   end

   // writes one block; optional expected digest; optional illegal write while busy
   task automatic send_block(input bit push, input logic [255:0] exp, input bit inject);
      int n;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (i == 1) begin
            check(valid_o == 1'b0, "R5 valid drop", {255'd0, valid_o}, 256'd0);
            check(ready_o == 1'b1, "R4 ready during block", {255'd0, ready_o}, 256'd1);
         end
         wr_i = 1'b1; wdata_i = blk[i];
      end
      if (push) exp_q.push_back(exp);
      @(negedge clk);
      wr_i = 1'b0;
      n = 0;
      while (!ready_o && n < 200) begin
         n++;
         wr_i = (inject && n == 10);
         wdata_i = 32'hdeadbeef;
         @(negedge clk);
         wr_i = 1'b0;
         if (inject && n == 10)
            check(err_o == 1'b1, "R6 err set", {255'd0, err_o}, 256'd1);
      end
      check(n == 57, "R4 busy length", 256'(n), 256'd57);
   endtask

   task automatic pulse_start(input bit with_wr);
      @(negedge clk);
      start_i = 1'b1; wr_i = with_wr; wdata_i = 32'h12345678;
      @(negedge clk);
      start_i = 1'b0; wr_i = 1'b0;
      check(ready_o && valid_o, "R2 flags after start", {254'd0, ready_o, valid_o}, 256'd3);
      check(sum_o == IV_V, "R1 IV after start", sum_o, IV_V);
      check(err_o == 1'b0, "R2 no err on start+write", {255'd0, err_o}, 256'd0);
   endtask

   task automatic load_abc();
      foreach (blk[i]) blk[i] = '0;
      blk[0] = 32'h61626380; blk[15] = 32'h00000018;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sum_o == IV_V, "R1 reset IV, R9 layout", sum_o, IV_V);
      check(ready_o && valid_o && !err_o, "R1 reset flags", {253'd0, ready_o, valid_o, err_o}, 256'd6);

      // single block "abc"
      load_abc();
      send_block(1, ABC_V, 0);

      // empty message after start
      pulse_start(0);
      foreach (blk[i]) blk[i] = '0;
      blk[0] = 32'h80000000;
      send_block(1, EMP_V, 0);

      // two-block message, illegal write injected in first busy window (R7, R8)
      pulse_start(0);
      blk = '{32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
              32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
              32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
              32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
      send_block(0, '0, 1);
      check(err_o == 1'b1, "R6 err sticky", {255'd0, err_o}, 256'd1);
      foreach (blk[i]) blk[i] = '0;
      blk[15] = 32'h000001c0;
      send_block(1, TWO_V, 0);
      repeat (2) @(negedge clk);
      check(err_o == 1'b1, "R6 err still set", {255'd0, err_o}, 256'd1);
      @(negedge clk) err_clr_i = 1'b1;
      @(negedge clk) err_clr_i = 1'b0;
      check(err_o == 1'b0, "R6 err cleared", {255'd0, err_o}, 256'd0);

      // partial block then start (with a simultaneous write): must restart cleanly
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); wr_i = 1'b1; wdata_i = 32'hcafe0000 + i;
      end
      @(negedge clk); wr_i = 1'b0;
      check(valid_o == 1'b0, "R5 valid low mid-block", {255'd0, valid_o}, 256'd0);
      pulse_start(1);
      load_abc();
      send_block(1, ABC_V, 0);
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R3 all digests seen", 256'(exp_q.size()), 256'd0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule